// File: doc/BRIEF.md
# OTP MAC Address Fetcher

This block reads a factory-written 48-bit Ethernet MAC address out of the one-time-programmable space of a serial NOR flash. It runs one read transaction on a single-bit SPI bus. The transaction starts by itself when synchronous reset is released, and again on each `start` pulse that arrives while the block is idle. The block only reads: it sends the dedicated OTP read opcode, the address of the MAC field and the dummy clocks. It then shifts in six bytes and presents them as one 48-bit word, with a single-cycle `mac_valid` strobe.

The bytes arrive highest-order first, so the first byte received becomes the top byte of `mac`. The block also compares the upper 24 bits against the expected vendor identifier and reports the result on `oui_ok`. The bit rate is set by the parameter `DIV`, and the minimum chip-select idle time is set by `CS_IDLE`.

Top module: `otp_mac_reader`

## Requirements
- R1: While chip select is low, MOSI carries the opcode 0x4B and then the 24-bit address 0x000020, most significant bit first, one bit per SCLK period. MOSI is 0 during the dummy and data phases and while chip select is high. No other opcode is ever sent.
- R2: A complete transaction has exactly 88 SCLK rising edges: 32 command bits, 8 dummy clocks and 48 data bits. Chip select rises after the last one.
- R3: SPI mode 0 is used. SCLK is low whenever chip select is high. Each bit lasts `DIV` system cycles: SCLK is low for the first `DIV/2` cycles and high for the rest. MOSI changes only while SCLK is low. MISO is captured at the end of the first SCLK-high cycle of a bit.
- R4: The first received data byte lands in `mac[47:40]` and the last in `mac[7:0]`. Within each byte the bits arrive MSB first.
- R5: `oui_ok` is 1 exactly when `mac[47:24]` equals 24'h00183E. It is updated together with `mac` and is 0 otherwise.
- R6: `mac_valid` is high for one cycle, in the cycle after the final SCLK period ends. `mac` and `oui_ok` keep their values until the next accepted start, which clears both to zero in the following cycle.
- R7: `busy` is high from the cycle after an accepted start until the last cycle of the final SCLK period. It is low while `mac_valid` is high.
- R8: After an accepted start, chip select stays high for `CS_IDLE` further cycles before it falls. Between two transactions it is therefore high for at least `CS_IDLE`+1 cycles.
- R9: `start` is accepted only while `busy` is low, including the cycle in which `mac_valid` is high. A `start` received while `busy` is high has no effect on the bus or the outputs.
- R10: While `rst` is high at a clock edge, the next cycle shows chip select high, SCLK low, `busy` low, and `mac`, `oui_ok` and `mac_valid` all zero. After `rst` falls, a fetch begins without any `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a new fetch (single-cycle pulse) |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| busy | output | 1 | Fetch in progress |
| mac | output | 48 | Assembled MAC address |
| mac_valid | output | 1 | One-cycle strobe: `mac` and `oui_ok` updated |
| oui_ok | output | 1 | Upper 24 bits match the expected vendor prefix |

## Verification
Two things can happen in the same cycle: the completion strobe of one fetch, and the acceptance of a new `start`. The bench provokes this by driving `start` in exactly the cycle in which `mac_valid` is seen high. It then expects `busy` to be high and `mac` to read zero one cycle later, and expects a second full frame to follow. A behavioural reference model runs alongside the design and predicts every output on every cycle. A flash model checks the command bits and the clock count of each frame.

// File: rtl/otp_mac_pkg.sv
package otp_mac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GUARD = 2'd1,
        ST_SHIFT = 2'd2
    } rd_state_e;

    localparam int unsigned MAC_BITS    = 48;
    localparam int unsigned PREFIX_BITS = 24;
    localparam int unsigned CMD_BITS    = 32;
    localparam logic [7:0]  OTP_READ_OP = 8'h4B;

endpackage

// File: rtl/otp_bit_timer.sv
module otp_bit_timer #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic smp_stb,
    output logic end_stb
);
    localparam int unsigned DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int unsigned LO = DIV / 2;

    typedef struct packed {
        logic [DW-1:0] div;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d.div = '0;
        end else if (tmr_q.div == DW'(DIV - 1)) begin
            tmr_d.div = '0;
        end else begin
            tmr_d.div = tmr_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '{div: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign sclk    = run && (tmr_q.div >= DW'(LO));
    assign smp_stb = run && (tmr_q.div == DW'(LO));
    assign end_stb = run && (tmr_q.div == DW'(DIV - 1));

    // R3
    sclk_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (run && end_stb) |=> !sclk);

endmodule

// File: rtl/otp_mac_capture.sv
module otp_mac_capture
    import otp_mac_pkg::*;
#(
    parameter logic [PREFIX_BITS-1:0] OUI = 24'h00183E
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                smp,
    input  logic                last,
    input  logic                miso,
    output logic [MAC_BITS-1:0] mac,
    output logic                oui_ok,
    output logic                valid
);
    typedef struct packed {
        logic [MAC_BITS-1:0] sr;
        logic [MAC_BITS-1:0] mac;
        logic                oui;
        logic                vld;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [MAC_BITS-1:0] sr_next;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = 1'b0;
        sr_next   = smp ? {cap_q.sr[MAC_BITS-2:0], miso} : cap_q.sr;
        cap_d.sr  = sr_next;
        if (clear) begin
            cap_d.sr  = '0;
            cap_d.mac = '0;
            cap_d.oui = 1'b0;
        end
        if (last) begin
            cap_d.mac = sr_next;
            cap_d.oui = (sr_next[MAC_BITS-1 -: PREFIX_BITS] == OUI);
            cap_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '{sr: '0, mac: '0, oui: 1'b0, vld: 1'b0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign mac    = cap_q.mac;
    assign oui_ok = cap_q.oui;
    assign valid  = cap_q.vld;

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R5
    oui_match_chk: assert property (@(posedge clk) disable iff (rst)
        oui_ok |-> (mac[MAC_BITS-1 -: PREFIX_BITS] == OUI));

    // R6
    mac_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!last && !clear) |=> ($stable(mac) && $stable(oui_ok)));

endmodule

// File: rtl/otp_mac_reader.sv
module otp_mac_reader
    import otp_mac_pkg::*;
#(
    parameter int unsigned              DIV      = 4,
    parameter int unsigned              CS_IDLE  = 3,
    parameter int unsigned              DUMMY    = 8,
    parameter logic [23:0]              MAC_ADDR = 24'h000020,
    parameter logic [PREFIX_BITS-1:0]   OUI      = 24'h00183E
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                spi_miso,
    output logic                spi_cs_n,
    output logic                spi_sclk,
    output logic                spi_mosi,
    output logic                busy,
    output logic [MAC_BITS-1:0] mac,
    output logic                mac_valid,
    output logic                oui_ok
);
    localparam int unsigned DATA_START = CMD_BITS + DUMMY;
    localparam int unsigned FRAME_BITS = DATA_START + MAC_BITS;
    localparam int unsigned BW         = $clog2(FRAME_BITS);
    localparam int unsigned GW         = (CS_IDLE > 1) ? $clog2(CS_IDLE + 1) : 1;

    typedef struct packed {
        rd_state_e             st;
        logic [GW-1:0]         gcnt;
        logic [BW-1:0]         bidx;
        logic [CMD_BITS-1:0]   cmd_sr;
        logic                  launch;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic clear_res;
    logic run;
    logic smp_stb, end_stb;
    logic cap_smp, cap_last;

    always_comb begin
        ctl_d     = ctl_q;
        clear_res = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start || ctl_q.launch) begin
                    ctl_d.st     = ST_GUARD;
                    ctl_d.gcnt   = '0;
                    ctl_d.launch = 1'b0;
                    clear_res    = 1'b1;
                end
            end
            ST_GUARD: begin
                if (ctl_q.gcnt == GW'(CS_IDLE - 1)) begin
                    ctl_d.st     = ST_SHIFT;
                    ctl_d.bidx   = '0;
                    ctl_d.cmd_sr = {OTP_READ_OP, MAC_ADDR};
                end else begin
                    ctl_d.gcnt = ctl_q.gcnt + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (end_stb) begin
                    if (ctl_q.bidx == BW'(FRAME_BITS - 1)) begin
                        ctl_d.st = ST_IDLE;
                    end else begin
                        ctl_d.bidx   = ctl_q.bidx + 1'b1;
                        ctl_d.cmd_sr = {ctl_q.cmd_sr[CMD_BITS-2:0], 1'b0};
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{st: ST_IDLE, gcnt: '0, bidx: '0, cmd_sr: '0, launch: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign run      = (ctl_q.st == ST_SHIFT);
    assign spi_cs_n = !run;
    assign spi_mosi = run && ctl_q.cmd_sr[CMD_BITS-1];
    assign busy     = (ctl_q.st != ST_IDLE);
    assign cap_smp  = smp_stb && (ctl_q.bidx >= BW'(DATA_START));
    assign cap_last = end_stb && (ctl_q.bidx == BW'(FRAME_BITS - 1));

    otp_bit_timer #(.DIV(DIV)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .sclk    (spi_sclk),
        .smp_stb (smp_stb),
        .end_stb (end_stb)
    );

    otp_mac_capture #(.OUI(OUI)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear_res),
        .smp    (cap_smp),
        .last   (cap_last),
        .miso   (spi_miso),
        .mac    (mac),
        .oui_ok (oui_ok),
        .valid  (mac_valid)
    );

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (spi_cs_n && !spi_sclk && !busy && !mac_valid));

    // R7
    busy_valid_excl_chk: assert property (@(posedge clk) disable iff (rst)
        mac_valid |-> !busy);

    // R8
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> ($past(spi_cs_n, 2) && busy));

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> $stable(spi_mosi));

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !spi_cs_n && !end_stb) |=> !spi_cs_n);

endmodule

// File: tb/tb_otp_mac_reader.sv
module tb_otp_mac_reader;
    localparam int DIV   = 4;
    localparam int CSI   = 3;
    localparam int LO    = DIV / 2;
    localparam int NBITS = 88;
    localparam logic [31:0] CMD = 32'h4B00_0020;
    localparam logic [23:0] VID = 24'h00183E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        spi_miso = 1'b0;
    logic        spi_cs_n, spi_sclk, spi_mosi, busy, mac_valid, oui_ok;
    logic [47:0] mac;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #4 clk = ~clk;

    otp_mac_reader dut (
        .clk(clk), .rst(rst), .start(start), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .busy(busy), .mac(mac), .mac_valid(mac_valid), .oui_ok(oui_ok)
    );

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // flash model
    logic [47:0] otp_word = 48'h0;
    int  rises = 0;
    int  xfers = 0;
    bit  active = 0;
    bit  aborting = 0;
    logic prev_sclk = 1'b0;
    logic [31:0] cmd_rx = 32'h0;

    always @(negedge clk) begin
        if (spi_cs_n === 1'b1) begin
            if (active) begin
                if (!aborting) begin
                    chk(cmd_rx == CMD, "R1 command bits", {16'h0, cmd_rx}, {16'h0, CMD});
                    chk(rises == NBITS, "R2 sclk edges", 48'(rises), 48'(NBITS));
                    xfers++;
                end
                aborting = 0;
                active = 0;
            end
            rises = 0;
            spi_miso = 1'b0;
        end else if (spi_cs_n === 1'b0) begin
            active = 1;
            if (spi_sclk && !prev_sclk) begin
                if (rises < 32) cmd_rx = {cmd_rx[30:0], spi_mosi};
                rises++;
            end
            if (!spi_sclk && prev_sclk)
                spi_miso = (rises >= 40 && rises < NBITS) ? otp_word[47 - (rises - 40)] : 1'b0;
        end
        prev_sclk = spi_sclk;
    end

    // reference model
    int   m_st = 0, m_cnt = 0, m_div = 0, m_bit = 0;
    bit   m_launch = 1;
    logic [47:0] m_sr = 0, m_mac = 0;
    logic m_oui = 0, m_vld = 0;
    bit   started = 0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_st = 0; m_launch = 1; m_mac = 0; m_oui = 0; m_vld = 0;
            m_div = 0; m_bit = 0; m_cnt = 0; m_sr = 0;
        end else begin
            m_vld = 0;
            case (m_st)
                0: if (start || m_launch) begin
                       m_st = 1; m_cnt = 0; m_launch = 0; m_mac = 0; m_oui = 0; m_sr = 0;
                   end
                1: if (m_cnt == CSI - 1) begin
                       m_st = 2; m_bit = 0; m_div = 0;
                   end else m_cnt++;
                default: begin
                    if (m_div == LO && m_bit >= 40) m_sr = {m_sr[46:0], spi_miso};
                    if (m_div == DIV - 1) begin
                        m_div = 0;
                        if (m_bit == NBITS - 1) begin
                            m_st = 0; m_mac = m_sr; m_oui = (m_sr[47:24] == VID); m_vld = 1;
                        end else m_bit++;
                    end else m_div++;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (started) begin
            logic e_cs, e_sclk, e_mosi, e_busy;
            e_cs   = (m_st != 2);
            e_sclk = (m_st == 2) && (m_div >= LO);
            e_mosi = (m_st == 2 && m_bit < 32) ? CMD[31 - m_bit] : 1'b0;
            e_busy = (m_st != 0);
            chk(spi_cs_n === e_cs, "R2 cs_n per-cycle", 48'(spi_cs_n), 48'(e_cs));
            chk(spi_sclk === e_sclk, "R3 sclk per-cycle", 48'(spi_sclk), 48'(e_sclk));
            chk(spi_mosi === e_mosi, "R1 mosi per-cycle", 48'(spi_mosi), 48'(e_mosi));
            chk(busy === e_busy, "R7 busy per-cycle", 48'(busy), 48'(e_busy));
            chk(mac === m_mac, "R4 mac per-cycle", mac, m_mac);
            chk(oui_ok === m_oui, "R5 oui_ok per-cycle", 48'(oui_ok), 48'(m_oui));
            chk(mac_valid === m_vld, "R6 valid per-cycle", 48'(mac_valid), 48'(m_vld));
        end
    end

    // R8: chip-select high time before each fall
    int hi_run = 0;
    always @(negedge clk) begin
        if (spi_cs_n === 1'b1) hi_run++;
        else if (spi_cs_n === 1'b0) begin
            if (hi_run > 0) chk(hi_run >= CSI + 1, "R8 cs high gap", 48'(hi_run), 48'(CSI + 1));
            hi_run = 0;
        end
    end

    task automatic wait_valid(output bit seen);
        seen = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (mac_valid === 1'b1) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=expired expected=finished");
        summary();
    end

    initial begin
        bit seen;
        int x0;
        otp_word = 48'h00183E_A1B2C3;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R10 reset bus idle", {46'h0, spi_cs_n, spi_sclk}, 48'h2);
        chk(busy === 1'b0 && mac_valid === 1'b0, "R10 reset busy/valid", {46'h0, busy, mac_valid}, 48'h0);
        chk(mac === 48'h0 && oui_ok === 1'b0, "R10 reset mac", mac, 48'h0);
        rst = 1'b0;

        // R10 automatic fetch, R4 and R5 good prefix
        wait_valid(seen);
        chk(seen, "R10 auto fetch completes", 48'(seen), 48'h1);
        chk(mac === 48'h00183E_A1B2C3, "R4 big-endian mac", mac, 48'h00183E_A1B2C3);
        chk(oui_ok === 1'b1, "R5 prefix match", 48'(oui_ok), 48'h1);
        chk(busy === 1'b0, "R7 busy low at valid", 48'(busy), 48'h0);
        @(negedge clk);
        chk(mac_valid === 1'b0, "R6 valid one cycle", 48'(mac_valid), 48'h0);
        repeat (10) @(negedge clk);
        chk(mac === 48'h00183E_A1B2C3, "R6 mac holds", mac, 48'h00183E_A1B2C3);
        chk(xfers == 1, "R2 one frame", 48'(xfers), 48'h1);

        // R5 bad prefix, R9 start while busy ignored
        otp_word = 48'h00183F_123456;
        pulse_start();
        chk(busy === 1'b1 && mac === 48'h0, "R6 clear on start", mac, 48'h0);
        @(negedge clk);
        pulse_start();
        repeat (60) @(negedge clk);
        pulse_start();
        wait_valid(seen);
        chk(mac === 48'h00183F_123456, "R4 second mac", mac, 48'h00183F_123456);
        chk(oui_ok === 1'b0, "R5 prefix mismatch", 48'(oui_ok), 48'h0);
        repeat (20) @(negedge clk);
        chk(xfers == 2 && busy === 1'b0, "R9 busy start ignored", 48'(xfers), 48'h2);

        // start in the same cycle as mac_valid
        otp_word = 48'h00183E_AA55F0;
        pulse_start();
        wait_valid(seen);
        otp_word = 48'h00183E_0F0F0F;
        x0 = xfers;
        pulse_start();
        chk(busy === 1'b1, "R9 start accepted in valid cycle", 48'(busy), 48'h1);
        chk(mac === 48'h0, "R6 cleared after valid-cycle start", mac, 48'h0);
        wait_valid(seen);
        chk(mac === 48'h00183E_0F0F0F && xfers == x0 + 1, "R4 back-to-back mac", mac, 48'h00183E_0F0F0F);

        // R10 reset in mid-frame, then automatic refetch
        otp_word = 48'h80183E_000001;
        pulse_start();
        repeat (100) @(negedge clk);
        aborting = 1;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R10 mid-frame reset bus", {46'h0, spi_cs_n, spi_sclk}, 48'h2);
        chk(busy === 1'b0 && mac === 48'h0, "R10 mid-frame reset state", mac, 48'h0);
        wait_valid(seen);
        chk(mac === 48'h80183E_000001, "R10 refetch after reset", mac, 48'h80183E_000001);
        chk(oui_ok === 1'b0, "R5 top-bit mismatch", 48'(oui_ok), 48'h0);
        repeat (5) @(negedge clk);
        summary();
    end
endmodule